// File: doc/BRIEF.md
# Isolated I/O Port Instruction Sequencer

This block sits on the processor side of an 8-bit system that keeps its I/O ports in an address space of their own. It executes the two-byte port input and port output instructions. Each instruction takes three machine cycles: an opcode fetch, a memory read that brings in the port-number byte, and a final cycle that either reads from the addressed port or writes to it. Every machine cycle lasts three clocks. The first clock raises an address-latch strobe. The second and third clocks hold an active-low read or write strobe low.

The block keeps a program counter, an accumulator and two temporary byte registers. The port byte is copied into both temporaries. During the I/O cycle those two copies drive the upper and lower halves of the address bus, and a select line marks that cycle, and only that cycle, as an I/O access. The bus is split into an address output, a data input and a data output with an enable, in place of a multiplexed bus. Any opcode other than the two port instructions is handled as a single fetch cycle that does nothing else.

Top module: `isoio_seq`

## Requirements
- R1: While reset is held, the outputs show the first clock of an opcode fetch: addr equals the reset PC (0 by default), io_sel=0, ale=1, rd_n=1, wr_n=1, dout_en=0, done=0 and acc=0.
- R2: Every machine cycle lasts exactly three clocks. ale is 1 in the first clock and 0 in the other two. The active strobe (rd_n or wr_n) is 0 in the second and third clocks and 1 in the first. addr and io_sel stay constant across all three clocks.
- R3: An opcode fetch is a memory read (io_sel=0, rd_n low) at the current PC. The opcode is the value of bus_in at the clock edge that ends the fetch.
- R4: When the opcode is 8'hDB (port input) or 8'hD3 (port output), the next machine cycle is a memory read at PC+1. The value of bus_in at the end of that cycle is the port number p.
- R5: The third machine cycle of a port instruction has io_sel=1 and addr = {p, p}, with p on bits 15..8 and also on bits 7..0.
- R6: For 8'hDB, the third cycle is a read (rd_n low, wr_n high). The value of bus_in at the clock edge that ends it is loaded into acc.
- R7: For 8'hD3, the third cycle is a write (wr_n low, rd_n high). dout_en is 1 and dout equals acc in the second and third clocks, and acc keeps its value.
- R8: Any opcode other than 8'hDB and 8'hD3 ends the instruction after the single fetch cycle, advances the PC by 1 and leaves acc unchanged.
- R9: A port instruction advances the PC by 2, so the next fetch is at the address after the port byte.
- R10: done is 1 for exactly one clock, the last clock of the last machine cycle of each instruction. The first clock of the next opcode fetch follows immediately.
- R11: rd_n and wr_n are never low together, and neither is low while ale is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Read data from memory or from the selected port |
| addr | output | 16 | Address bus: the PC, or the port byte on both halves |
| io_sel | output | 1 | 1 = I/O access, 0 = memory access |
| ale | output | 1 | Address-latch strobe, high in the first clock of each machine cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dout | output | 8 | Write data (the accumulator) |
| dout_en | output | 1 | dout is valid and driven onto the bus |
| acc | output | 8 | Accumulator contents |
| done | output | 1 | One-clock pulse in the last clock of each instruction |

## Verification
The assertions assume only that reset starts the block cleanly. They make no assumption about bus_in, because every value the block samples is legal: any non-port opcode is a no-op, and any port byte is a valid port. The stimulus is a program image laid out from address 0. It begins with directed cases: ports 8'h00 and 8'hFF, port instructions back to back, and opcodes one step away from the two port opcodes. The rest of the image is random instructions, and every port instruction fits whole below the end of the program, so the sequencer never runs into unwritten memory.

// File: rtl/isoio_seq.sv
module isoio_seq #(
  parameter int unsigned DATA_W = 8,
  parameter logic [2*DATA_W-1:0] PC_RST = '0,
  parameter logic [DATA_W-1:0] OP_IN = 8'hDB,
  parameter logic [DATA_W-1:0] OP_OUT = 8'hD3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   bus_in,
  output logic [2*DATA_W-1:0] addr,
  output logic                io_sel,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_en,
  output logic [DATA_W-1:0]   acc,
  output logic                done
);
  localparam int unsigned ADDR_W = 2 * DATA_W;

  typedef enum logic [1:0] {M_FETCH, M_PORT, M_IO} mcyc_t;

  mcyc_t             mcyc;
  logic [1:0]        tst;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, w_q, z_q;

  logic last_t, fetch_io, is_out, strobe;

  assign last_t   = (tst == 2'd2);
  assign fetch_io = (bus_in == OP_IN) || (bus_in == OP_OUT);
  assign is_out   = (mcyc == M_IO) && (ir == OP_OUT);
  assign strobe   = (tst != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcyc <= M_FETCH;
      tst  <= 2'd0;
      pc   <= PC_RST;
      ir   <= '0;
      w_q  <= '0;
      z_q  <= '0;
      acc  <= '0;
    end else if (!last_t) begin
      tst <= tst + 2'd1;
    end else begin
      tst <= 2'd0;
      case (mcyc)
        M_FETCH: begin
          ir   <= bus_in;
          pc   <= pc + 1'b1;
          mcyc <= fetch_io ? M_PORT : M_FETCH;
        end
        M_PORT: begin
          w_q  <= bus_in;
          z_q  <= bus_in;
          pc   <= pc + 1'b1;
          mcyc <= M_IO;
        end
        default: begin
          if (ir == OP_IN) acc <= bus_in;
          mcyc <= M_FETCH;
        end
      endcase
    end
  end

  assign addr    = (mcyc == M_IO) ? {w_q, z_q} : pc;
  assign io_sel  = (mcyc == M_IO);
  assign ale     = !strobe;
  assign rd_n    = !(strobe && !is_out);
  assign wr_n    = !(strobe && is_out);
  assign dout_en = strobe && is_out;
  assign dout    = dout_en ? acc : '0;
  assign done    = last_t && ((mcyc == M_IO) || ((mcyc == M_FETCH) && !fetch_io));

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) && (ale -> (rd_n && wr_n)));

  a_r5_io_addr_dup: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (addr[ADDR_W-1:DATA_W] == addr[DATA_W-1:0]));

  a_r5_io_starts_at_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel) |-> ale);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> ($stable(addr) && $stable(io_sel)));

  a_r10_done_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ale && !io_sel));

  a_r7_out_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(dout) && $stable(acc)));

  a_r6_io_read_loads_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && done && !rd_n) |=> (acc == $past(bus_in)));
endmodule

// File: tb/isoio_seq_tb_top.sv
`timescale 1ns/1ps
module isoio_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_in;
  logic [15:0] addr;
  logic        io_sel, ale, rd_n, wr_n, dout_en, done;
  logic [7:0]  dout, acc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] prog [256];

  always #2 clk = ~clk;

  function automatic logic [7:0] port_data(input logic [7:0] p);
    return (p * 8'd37) ^ 8'h5C;
  endfunction

  assign bus_in = io_sel ? port_data(addr[7:0]) : prog[addr[7:0]];

  isoio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .addr(addr), .io_sel(io_sel),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dout(dout), .dout_en(dout_en),
    .acc(acc), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_mc(input logic [15:0] ea, input bit eio, input bit ewr,
                        input bit edone, input logic [7:0] eacc);
    for (int t = 0; t < 3; t++) begin
      if (t > 0) @(negedge clk);
      chk(addr == ea, "R3 R4 R5 R9 addr", addr, ea);
      chk(io_sel == eio, "R5 io_sel", io_sel, eio);
      chk(ale == (t == 0), "R2 ale", ale, t == 0);
      chk(rd_n == ((t == 0) || ewr), "R2 R6 rd_n", rd_n, (t == 0) || ewr);
      chk(wr_n == ((t == 0) || !ewr), "R2 R7 wr_n", wr_n, (t == 0) || !ewr);
      chk(dout_en == (ewr && t > 0), "R7 dout_en", dout_en, ewr && t > 0);
      if (ewr && t > 0) chk(dout == eacc, "R7 dout", dout, eacc);
      chk(done == (edone && t == 2), "R10 done", done, edone && t == 2);
      if (t == 0) chk(acc == eacc, "R6 R8 acc", acc, eacc);
    end
    @(negedge clk);
  endtask

  initial begin
    int idx;
    logic [15:0] pc;
    logic [7:0] a, op, p;
    void'($urandom(32'd4242));
    foreach (prog[i]) prog[i] = 8'h00;
    prog[0] = 8'hDB; prog[1] = 8'h00;
    prog[2] = 8'hD3; prog[3] = 8'hFF;
    prog[4] = 8'h00;
    prog[5] = 8'hDB; prog[6] = 8'hFF;
    prog[7] = 8'hD3; prog[8] = 8'h00;
    prog[9] = 8'hDA; prog[10] = 8'hDC; prog[11] = 8'hD2; prog[12] = 8'hD4;
    prog[13] = 8'hD3; prog[14] = 8'h5A;
    idx = 15;
    while (idx < 246) begin
      case ($urandom % 3)
        0: begin prog[idx] = 8'hDB; prog[idx+1] = 8'($urandom); idx += 2; end
        1: begin prog[idx] = 8'hD3; prog[idx+1] = 8'($urandom); idx += 2; end
        default: begin
          op = 8'($urandom);
          while (op == 8'hDB || op == 8'hD3) op = 8'($urandom);
          prog[idx] = op; idx += 1;
        end
      endcase
    end

    repeat (2) @(negedge clk);
    // R1 reset state
    chk(addr == 16'h0000, "R1 addr", addr, 0);
    chk(io_sel == 1'b0, "R1 io_sel", io_sel, 0);
    chk(ale == 1'b1, "R1 ale", ale, 1);
    chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 2'b11);
    chk(!dout_en && !done, "R1 dout_en/done", {dout_en, done}, 0);
    chk(acc == 8'h00, "R1 acc", acc, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);

    pc = 16'h0000; a = 8'h00;
    while (pc < 16'(idx)) begin
      op = prog[pc[7:0]];
      if (op == 8'hDB || op == 8'hD3) begin
        run_mc(pc, 1'b0, 1'b0, 1'b0, a);
        pc++;
        p = prog[pc[7:0]];
        run_mc(pc, 1'b0, 1'b0, 1'b0, a);
        pc++; // R9
        run_mc({p, p}, 1'b1, op == 8'hD3, 1'b1, a);
        if (op == 8'hDB) a = port_data(p);
      end else begin
        run_mc(pc, 1'b0, 1'b0, 1'b1, a); // R8
        pc++;
      end
    end
    chk(acc == a, "R6 R7 final acc", acc, a);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule